// File: doc/BRIEF.md
# Condition Code and Branch Evaluator

This block keeps the three-flag condition state of a small 16-bit processor and decides whether a conditional branch is taken. It watches the register writeback port. Each cycle it receives a write enable, the 4-bit opcode of the retiring instruction and the value being written. When the write is enabled and the opcode belongs to the fixed list of flag-setting instructions, the flags are reloaded from that value. The flags are read as a two's complement number that is negative, zero or strictly positive.

The flags are held as a three-state machine. Its states are `CC_NEG`, `CC_ZERO` and `CC_POS`, and its reset state is `CC_ZERO`. There is one named transition, `UPDATE`. On a qualifying write it moves from any state to the class of the written value, which may be the state it is already in. On any other cycle the state holds, which is the `HOLD` transition. The outputs `flag_n`, `flag_z` and `flag_p` are decoded from the state, so exactly one of them is high.

A second input carries the instruction being evaluated for branching. When its opcode field is the branch code, its three mask bits are compared with the current flags, and `br_taken` is raised combinationally if any enabled mask bit matches the asserted flag.

Top module: `cc_branch_unit`

## Requirements
- R1: A qualifying write whose value has bit 15 set makes `flag_n`=1, `flag_z`=0 and `flag_p`=0 from the next clock edge.
- R2: A qualifying write of value 0 makes `flag_z`=1, `flag_n`=0 and `flag_p`=0 from the next clock edge.
- R3: A qualifying write of a nonzero value with bit 15 clear makes `flag_p`=1, `flag_n`=0 and `flag_z`=0 from the next clock edge.
- R4: Exactly one of `flag_n`, `flag_z` and `flag_p` is high in every cycle, including reset.
- R5: A write qualifies only when `wb_en`=1 and `wb_op` is one of 0001, 0101, 1001, 0010, 0110, 1010 or 1110.
- R6: When `wb_en`=0, or `wb_op` is any other code, the flags keep their previous values.
- R7: While `rst_n`=0, and on the first cycle after reset, the flags are `flag_z`=1, `flag_n`=0 and `flag_p`=0.
- R8: `br_taken` is 1 exactly when `br_instr[15:12]`=0000 and the bitwise AND of the mask {`br_instr[11]`=n, `br_instr[10]`=z, `br_instr[9]`=p} with {`flag_n`, `flag_z`, `flag_p`} is nonzero. It is a combinational output in the same cycle.
- R9: A branch with mask 111 is always taken, and a branch with mask 000 is never taken.
- R10: When a flag update and a branch test occur in the same cycle, the branch uses the flags as they were before that cycle's update.
- R11: When `br_instr[15:12]` is not 0000, `br_taken`=0 whatever the mask bits and flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wb_en | input | 1 | Register writeback enable |
| wb_op | input | 4 | Opcode of the retiring instruction |
| wb_data | input | 16 | Value being written back |
| br_instr | input | 16 | Instruction under branch evaluation |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |
| br_taken | output | 1 | Branch taken decision |

## Verification
Directed writes of 0, 0x8000, 0x7FFF, 0xFFFF and 1 tell apart the sign-bit boundary, the zero test and the smallest positive value. Each of these writes is followed by all eight masks, which shows that every mask bit is tied to its own flag. Writes under every non-qualifying opcode and with `wb_en` low are interleaved with known flag states to show that they leave the flags untouched. A long run of random opcodes, values and branch instructions then checks the one-hot rule and the taken decision against a bench model every cycle, including cycles where an update and a branch test coincide.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2
    } cc_state_t;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_BR  = 4'b0000;
    localparam logic [OP_W-1:0] OP_ADD = 4'b0001;
    localparam logic [OP_W-1:0] OP_AND = 4'b0101;
    localparam logic [OP_W-1:0] OP_NOT = 4'b1001;
    localparam logic [OP_W-1:0] OP_LD  = 4'b0010;
    localparam logic [OP_W-1:0] OP_LDR = 4'b0110;
    localparam logic [OP_W-1:0] OP_LDI = 4'b1010;
    localparam logic [OP_W-1:0] OP_LEA = 4'b1110;

    // True for the opcodes that write a general register
    function automatic logic op_sets_cc(input logic [OP_W-1:0] op);
        logic hit;
        case (op)
            OP_ADD, OP_AND, OP_NOT,
            OP_LD, OP_LDR, OP_LDI, OP_LEA: hit = 1'b1;
            default:                       hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cc_classify.sv
module cc_classify
    import cc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] value,
    output cc_state_t         cls
);

    localparam int SIGN_BIT = DATA_W - 1;

    always_comb begin
        if (value[SIGN_BIT]) begin
            cls = CC_NEG;
        end else if (value == '0) begin
            cls = CC_ZERO;
        end else begin
            cls = CC_POS;
        end
    end

endmodule

// File: rtl/cc_state_reg.sv
module cc_state_reg
    import cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      upd,
    input  cc_state_t cls,
    output logic      flag_n,
    output logic      flag_z,
    output logic      flag_p
);

    cc_state_t state;
    cc_state_t state_nxt;

    // Transition selection: UPDATE jumps to the class, HOLD keeps state
    always_comb begin
        state_nxt = state;
        if (upd) begin
            unique case (cls)
                CC_NEG:  state_nxt = CC_NEG;
                CC_ZERO: state_nxt = CC_ZERO;
                CC_POS:  state_nxt = CC_POS;
                default: state_nxt = CC_ZERO;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CC_ZERO;
        end else begin
            state <= state_nxt;
        end
    end

    // Output decode
    always_comb begin
        flag_n = 1'b0;
        flag_z = 1'b0;
        flag_p = 1'b0;
        unique case (state)
            CC_NEG:  flag_n = 1'b1;
            CC_ZERO: flag_z = 1'b1;
            CC_POS:  flag_p = 1'b1;
            default: flag_z = 1'b1;
        endcase
    end

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({flag_n, flag_z, flag_p}) == 1); // R4

    AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable({flag_n, flag_z, flag_p})); // R6

    AST_NEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && cls == CC_NEG) |=> flag_n); // R1

    AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && cls == CC_ZERO) |=> flag_z); // R2

    AST_POS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && cls == CC_POS) |=> flag_p); // R3

endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
    import cc_pkg::*;
#(
    parameter int INSTR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic [2:0]         flags_nzp,
    output logic               taken
);

    localparam int OP_LSB   = INSTR_W - OP_W;
    localparam int MASK_LSB = OP_LSB - 3;

    logic [OP_W-1:0] op;
    logic [2:0]      mask_nzp;
    logic            is_br;

    assign op       = instr[INSTR_W-1:OP_LSB];
    assign mask_nzp = instr[OP_LSB-1:MASK_LSB];
    assign is_br    = (op == OP_BR);

    always_comb begin
        taken = 1'b0;
        if (is_br) begin
            taken = |(mask_nzp & flags_nzp);
        end
    end

    AST_ALL_MASK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (is_br && mask_nzp == 3'b111) |-> taken); // R9

    AST_EMPTY_MASK_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_nzp == 3'b000) |-> !taken); // R9

    AST_NON_BRANCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !is_br |-> !taken); // R11

endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
    import cc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_en,
    input  logic [3:0]        wb_op,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [DATA_W-1:0] br_instr,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_p,
    output logic              br_taken
);

    cc_state_t wb_cls;
    logic      wb_upd;

    assign wb_upd = wb_en && op_sets_cc(wb_op); // R5

    cc_classify #(.DATA_W(DATA_W)) u_classify (
        .value (wb_data),
        .cls   (wb_cls)
    );

    cc_state_reg u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (wb_upd),
        .cls    (wb_cls),
        .flag_n (flag_n),
        .flag_z (flag_z),
        .flag_p (flag_p)
    );

    cc_branch_eval #(.INSTR_W(DATA_W)) u_branch (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr     (br_instr),
        .flags_nzp ({flag_n, flag_z, flag_p}),
        .taken     (br_taken)
    );

    AST_NO_STORE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !op_sets_cc(wb_op)) |=> $stable({flag_n, flag_z, flag_p})); // R6

endmodule

// File: tb/cc_branch_unit_tb.sv
module cc_branch_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_en = 1'b0;
    logic [3:0]  wb_op = 4'h0;
    logic [15:0] wb_data = 16'h0;
    logic [15:0] br_instr = 16'hF000;
    logic        flag_n, flag_z, flag_p, br_taken;

    int total = 0;
    int bad = 0;
    logic [2:0] mdl = 3'b010;   // model flags {n,z,p}

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .wb_op(wb_op),
        .wb_data(wb_data), .br_instr(br_instr),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
        .br_taken(br_taken)
    );

    function automatic logic qual(input logic [3:0] op);
        return op == 4'b0001 || op == 4'b0101 || op == 4'b1001 ||
               op == 4'b0010 || op == 4'b0110 || op == 4'b1010 ||
               op == 4'b1110;
    endfunction

    function automatic logic [2:0] cls_of(input logic [15:0] v);
        if ($signed(v) < 0) return 3'b100;
        if (v == 16'h0)     return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic exp_taken(input logic [15:0] ins, input logic [2:0] f);
        return (ins[15:12] == 4'b0000) && ((ins[11:9] & f) != 3'b000);
    endfunction

    task automatic cmp(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle; check taken and flags before the edge, update model at edge
    task automatic step(input logic en, input logic [3:0] op, input logic [15:0] d,
                        input logic [15:0] ins, input string req);
        @(negedge clk);
        wb_en = en; wb_op = op; wb_data = d; br_instr = ins;
        #1;
        cmp({req, " flags"}, {1'b0, flag_n, flag_z, flag_p}, {1'b0, mdl});
        cmp("R4 onehot", {3'b0, ($countones({flag_n, flag_z, flag_p}) == 1)}, 4'h1);
        cmp({req, " taken"}, {3'b0, br_taken}, {3'b0, exp_taken(ins, mdl)});
        @(posedge clk);
        if (en && qual(op)) mdl = cls_of(d);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        #(CLK_PERIOD * 3 + 2);
        // R7: reset state
        cmp("R7 reset flags", {1'b0, flag_n, flag_z, flag_p}, 4'b0010);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 4'h0, 16'h0, 16'h4000, "R7 first cycle");

        // R1/R2/R3 boundaries with every mask (R8, R9)
        begin
            logic [15:0] vals [5] = '{16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF, 16'h0001};
            foreach (vals[i]) begin
                step(1'b1, 4'b0001, vals[i], 16'hF000, "R5 ADD load");
                for (int m = 0; m < 8; m++) begin
                    step(1'b0, 4'h0, 16'h0, {4'b0000, m[2:0], 9'h0},
                         cls_of(vals[i]) == 3'b100 ? "R1 R8 R9" :
                         cls_of(vals[i]) == 3'b010 ? "R2 R8 R9" : "R3 R8 R9");
                end
            end
        end

        // R5: each qualifying opcode loads; R6: others do not
        for (int op = 0; op < 16; op++) begin
            step(1'b1, 4'b0110, 16'h0005, 16'hF000, "R5 LDR load");
            step(1'b1, op[3:0], 16'h8001, 16'h0E00, qual(op[3:0]) ? "R5 qualify" : "R6 ignore");
            step(1'b0, 4'h0, 16'h0, 16'h0E00, qual(op[3:0]) ? "R5 result" : "R6 result");
        end
        // R6: wb_en low with a qualifying opcode
        step(1'b1, 4'b1110, 16'h0000, 16'hF000, "R5 LEA load");
        step(1'b0, 4'b0001, 16'hFFFF, 16'h0400, "R6 en low");
        step(1'b0, 4'h0, 16'h0, 16'h0400, "R6 en low result");

        // R10: update and branch in the same cycle use old flags
        step(1'b1, 4'b0010, 16'h0000, 16'h0400, "R10 same cycle");
        step(1'b1, 4'b1010, 16'h9000, 16'h0400, "R10 old z");
        step(1'b0, 4'h0, 16'h0, 16'h0400, "R10 new n");

        // R11: non-branch opcodes never taken
        for (int op = 1; op < 16; op++) begin
            step(1'b0, 4'h0, 16'h0, {op[3:0], 12'hE00}, "R11 non branch");
        end

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] d;
            logic [15:0] ins;
            d = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
            ins = 16'($urandom);
            if ($urandom % 2 == 0) ins[15:12] = 4'b0000;
            step(1'($urandom), 4'($urandom), d, ins, "R8 R10 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule